// File: doc/BRIEF.md
# Paged program counter unit

This block keeps the 13-bit instruction fetch address for a small 8-bit controller core whose program store holds 4K words. On each clock it either holds the address, steps it by one, or loads a new value. A new value comes from one of three places: an ALU result written to the low address byte, an 11-bit branch target carried by a jump or call, or an address restored from the return stack.

The five upper address bits are never written directly. They come from a separate 5-bit upper-address latch. The way the latch is merged into the address depends on the load. A low-byte write takes latch bits 3..0 as address bits 11..8. A jump or call takes latch bits 4..3 as address bits 12..11. Address bit 12 is always cleared on these two loads, so the reachable range is 000h to FFFh and latch bit 4 has no effect on the address. A restore from the return stack is taken as all 13 bits and does not use the latch. The block drives the push value for the stack, which is the next sequential address, and the latch contents are readable on their own port.

Top module: `pcu_top`

## Requirements
- R1: An active-low asynchronous reset clears the address to 000h and the upper-address latch to 00h.
- R2: With only the step input active, the address goes to (address + 1) mod 2000h on the next clock. 1FFFh steps to 0000h.
- R3: A low-byte write loads {0, latch[3:0], data[7:0]}. There is no carry into bits 12..8, so a computed table jump that overflows the low byte wraps inside the same 256-word block.
- R4: A jump/call loads {0, latch[3], imm[10:0]}. Latch bit 3 picks the 2K page.
- R5: Latch bit 4 has no effect on the address: bit 12 reads 0 after every low-byte write or jump, even when latch bit 4 is 1. The latch read port still returns all 5 bits as written.
- R6: A stack restore loads the 13-bit restore input unchanged, and the latch keeps its value.
- R7: The push output always equals (address + 1) mod 2000h.
- R8: When several load inputs are active together, priority is restore > jump > low-byte write > step.
- R9: The latch changes only on its own write strobe. A low-byte write or jump in the same cycle as a latch write uses the latch value from before that write.
- R10: With no control input active, the address holds its value.
- R11: The low-byte read port always equals address bits 7..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Advance to next sequential address |
| lowwr_i | input | 1 | Write ALU result into address low byte |
| lowwr_data_i | input | 8 | ALU result for low-byte write |
| jmp_i | input | 1 | Jump or call with immediate target |
| jmp_imm_i | input | 11 | Immediate branch target |
| rst_ld_i | input | 1 | Load address from return stack |
| rst_addr_i | input | 13 | Address popped from return stack |
| hi_wr_i | input | 1 | Write strobe for the upper-address latch |
| hi_wr_data_i | input | 5 | New latch contents |
| fetch_addr_o | output | 13 | Current fetch address |
| low_rd_o | output | 8 | Readable low address byte |
| hi_rd_o | output | 5 | Readable latch contents |
| push_addr_o | output | 13 | Return address for the stack push |

## Verification
The assertions for the low-byte and jump loads rebuild the expected address from the latch read port as sampled one cycle earlier. This is correct only because a same-cycle latch write must not reach the loaded address, and the stimulus drives latch writes together with loads on purpose to test that. The per-source checks state the inputs that must be idle for each one to apply, so any mix of controls is legal. The bench sets every input at the falling edge and keeps them at zero during reset, so the antecedents never see unknown values.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
    localparam int PC_W    = 13;
    localparam int LOW_W   = 8;
    localparam int IMM_W   = 11;
    localparam int LATCH_W = 5;
    localparam int REACH_W = 12;

    typedef enum logic [2:0] {
        SRC_HOLD,
        SRC_STEP,
        SRC_LOW,
        SRC_JMP,
        SRC_STACK
    } pc_src_e;

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } pc_state_t;

    typedef struct packed {
        logic [LATCH_W-1:0] hi;
    } hi_state_t;
endpackage

// File: rtl/pcu_upper_latch.sv
module pcu_upper_latch
    import pcu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [LATCH_W-1:0] wr_data_i,
    output logic [LATCH_W-1:0] q_o
);
    hi_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) st_d.hi = wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.hi;
endmodule

// File: rtl/pcu_next_sel.sv
module pcu_next_sel
    import pcu_pkg::*;
#(
    parameter int PCW = PC_W,
    parameter int LW  = LOW_W,
    parameter int IW  = IMM_W,
    parameter int HW  = LATCH_W,
    parameter int RW  = REACH_W
) (
    input  logic [PCW-1:0] pc_q_i,
    input  logic [HW-1:0]  hi_i,
    input  logic           step_i,
    input  logic           lowwr_i,
    input  logic [LW-1:0]  lowwr_data_i,
    input  logic           jmp_i,
    input  logic [IW-1:0]  jmp_imm_i,
    input  logic           rst_ld_i,
    input  logic [PCW-1:0] rst_addr_i,
    output logic [PCW-1:0] seq_o,
    output logic [PCW-1:0] pc_d_o
);
    localparam int LOW_HI = PCW - LW;
    localparam int JMP_HI = PCW - IW;

    logic [PCW-1:0] low_raw, jmp_raw, low_trim, jmp_trim;
    pc_src_e        src;

    assign seq_o   = pc_q_i + PCW'(1);
    assign low_raw = {hi_i[LOW_HI-1:0], lowwr_data_i};
    assign jmp_raw = {hi_i[HW-1 -: JMP_HI], jmp_imm_i};

    generate
        if (RW < PCW) begin : g_trim
            localparam logic [PCW-1:0] REACH_MASK = {{(PCW-RW){1'b0}}, {RW{1'b1}}};
            assign low_trim = low_raw & REACH_MASK;
            assign jmp_trim = jmp_raw & REACH_MASK;
        end else begin : g_full
            assign low_trim = low_raw;
            assign jmp_trim = jmp_raw;
        end
    endgenerate

    always_comb begin
        if (rst_ld_i)     src = SRC_STACK;
        else if (jmp_i)   src = SRC_JMP;
        else if (lowwr_i) src = SRC_LOW;
        else if (step_i)  src = SRC_STEP;
        else              src = SRC_HOLD;

        unique case (src)
            SRC_STACK: pc_d_o = rst_addr_i;
            SRC_JMP:   pc_d_o = jmp_trim;
            SRC_LOW:   pc_d_o = low_trim;
            SRC_STEP:  pc_d_o = seq_o;
            default:   pc_d_o = pc_q_i;
        endcase
    end
endmodule

// File: rtl/pcu_top.sv
module pcu_top
    import pcu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_i,
    input  logic               lowwr_i,
    input  logic [LOW_W-1:0]   lowwr_data_i,
    input  logic               jmp_i,
    input  logic [IMM_W-1:0]   jmp_imm_i,
    input  logic               rst_ld_i,
    input  logic [PC_W-1:0]    rst_addr_i,
    input  logic               hi_wr_i,
    input  logic [LATCH_W-1:0] hi_wr_data_i,
    output logic [PC_W-1:0]    fetch_addr_o,
    output logic [LOW_W-1:0]   low_rd_o,
    output logic [LATCH_W-1:0] hi_rd_o,
    output logic [PC_W-1:0]    push_addr_o
);
    pc_state_t          st_d, st_q;
    logic [LATCH_W-1:0] hi_q;
    logic [PC_W-1:0]    pc_next, pc_seq;

    pcu_upper_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (hi_wr_i),
        .wr_data_i (hi_wr_data_i),
        .q_o       (hi_q)
    );

    pcu_next_sel u_next (
        .pc_q_i       (st_q.pc),
        .hi_i         (hi_q),
        .step_i       (step_i),
        .lowwr_i      (lowwr_i),
        .lowwr_data_i (lowwr_data_i),
        .jmp_i        (jmp_i),
        .jmp_imm_i    (jmp_imm_i),
        .rst_ld_i     (rst_ld_i),
        .rst_addr_i   (rst_addr_i),
        .seq_o        (pc_seq),
        .pc_d_o       (pc_next)
    );

    always_comb begin
        st_d    = st_q;
        st_d.pc = pc_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fetch_addr_o = st_q.pc;
    assign low_rd_o     = st_q.pc[LOW_W-1:0];
    assign hi_rd_o      = hi_q;
    assign push_addr_o  = pc_seq;
endmodule

// File: rtl/pcu_chk.sv
module pcu_chk
    import pcu_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               step_i,
    input logic               lowwr_i,
    input logic [LOW_W-1:0]   lowwr_data_i,
    input logic               jmp_i,
    input logic [IMM_W-1:0]   jmp_imm_i,
    input logic               rst_ld_i,
    input logic [PC_W-1:0]    rst_addr_i,
    input logic               hi_wr_i,
    input logic [PC_W-1:0]    fetch_addr_o,
    input logic [LATCH_W-1:0] hi_rd_o
);
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (fetch_addr_o == '0 && hi_rd_o == '0));

    a_r2_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !lowwr_i && !jmp_i && !rst_ld_i)
        |=> fetch_addr_o == PC_W'($past(fetch_addr_o) + PC_W'(1)));

    // R5 also covered: bit 12 must be 0 whatever latch bit 4 held
    a_r3_low_merge: assert property (@(posedge clk) disable iff (!rst_n)
        (lowwr_i && !jmp_i && !rst_ld_i)
        |=> fetch_addr_o == {1'b0, $past(hi_rd_o[3:0]), $past(lowwr_data_i)});

    a_r4_jmp_page: assert property (@(posedge clk) disable iff (!rst_n)
        (jmp_i && !rst_ld_i)
        |=> fetch_addr_o == {1'b0, $past(hi_rd_o[3]), $past(jmp_imm_i)});

    a_r6_stack_load: assert property (@(posedge clk) disable iff (!rst_n)
        rst_ld_i |=> fetch_addr_o == $past(rst_addr_i));

    a_r9_latch_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_wr_i |=> $stable(hi_rd_o));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !lowwr_i && !jmp_i && !rst_ld_i) |=> $stable(fetch_addr_o));
endmodule

bind pcu_top pcu_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .step_i       (step_i),
    .lowwr_i      (lowwr_i),
    .lowwr_data_i (lowwr_data_i),
    .jmp_i        (jmp_i),
    .jmp_imm_i    (jmp_imm_i),
    .rst_ld_i     (rst_ld_i),
    .rst_addr_i   (rst_addr_i),
    .hi_wr_i      (hi_wr_i),
    .fetch_addr_o (fetch_addr_o),
    .hi_rd_o      (hi_rd_o)
);

// File: tb/tb_pcu_top.sv
module tb_pcu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 1'b0, lowwr_i = 1'b0, jmp_i = 1'b0, rst_ld_i = 1'b0, hi_wr_i = 1'b0;
    logic [7:0]  lowwr_data_i = '0;
    logic [10:0] jmp_imm_i = '0;
    logic [12:0] rst_addr_i = '0;
    logic [4:0]  hi_wr_data_i = '0;
    logic [12:0] fetch_addr_o, push_addr_o;
    logic [7:0]  low_rd_o;
    logic [4:0]  hi_rd_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pcu_top dut (.*);

    typedef struct packed {
        logic        hw;
        logic [4:0]  hd;
        logic        st;
        logic        lw;
        logic [7:0]  ld;
        logic        jp;
        logic [10:0] im;
        logic        rl;
        logic [12:0] ra;
        logic [12:0] epc;
        logic [4:0]  ehi;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{1'b0,5'h00,1'b1,1'b0,8'h00,1'b0,11'h000,1'b0,13'h0000,13'h0001,5'h00,8'd2},  // R2
        '{1'b0,5'h00,1'b1,1'b0,8'h00,1'b0,11'h000,1'b0,13'h0000,13'h0002,5'h00,8'd2},  // R2
        '{1'b1,5'h0B,1'b0,1'b0,8'h00,1'b0,11'h000,1'b0,13'h0000,13'h0002,5'h0B,8'd10}, // R10 hold
        '{1'b0,5'h00,1'b0,1'b1,8'h34,1'b0,11'h000,1'b0,13'h0000,13'h0B34,5'h0B,8'd3},  // R3
        '{1'b0,5'h00,1'b1,1'b0,8'h00,1'b0,11'h000,1'b0,13'h0000,13'h0B35,5'h0B,8'd2},  // R2
        '{1'b0,5'h00,1'b0,1'b0,8'h00,1'b1,11'h123,1'b0,13'h0000,13'h0923,5'h0B,8'd4},  // R4 page 1
        '{1'b1,5'h10,1'b0,1'b1,8'hFF,1'b0,11'h000,1'b0,13'h0000,13'h0BFF,5'h10,8'd9},  // R9 old latch
        '{1'b0,5'h00,1'b1,1'b0,8'h00,1'b0,11'h000,1'b0,13'h0000,13'h0C00,5'h10,8'd2},  // R2 carry
        '{1'b0,5'h00,1'b0,1'b1,8'h05,1'b0,11'h000,1'b0,13'h0000,13'h0005,5'h10,8'd5},  // R5
        '{1'b0,5'h00,1'b0,1'b0,8'h00,1'b1,11'h7FF,1'b0,13'h0000,13'h07FF,5'h10,8'd5},  // R5 jump
        '{1'b0,5'h00,1'b1,1'b0,8'h00,1'b1,11'h001,1'b1,13'h1ABC,13'h1ABC,5'h10,8'd8},  // R8 stack wins
        '{1'b0,5'h00,1'b1,1'b0,8'h00,1'b0,11'h000,1'b0,13'h0000,13'h1ABD,5'h10,8'd2},  // R2
        '{1'b0,5'h00,1'b0,1'b0,8'h00,1'b0,11'h000,1'b1,13'h1FFF,13'h1FFF,5'h10,8'd6},  // R6
        '{1'b0,5'h00,1'b1,1'b0,8'h00,1'b0,11'h000,1'b0,13'h0000,13'h0000,5'h10,8'd2},  // R2 wrap
        '{1'b0,5'h00,1'b1,1'b1,8'h77,1'b1,11'h155,1'b0,13'h0000,13'h0155,5'h10,8'd8},  // R8 jump wins
        '{1'b0,5'h00,1'b1,1'b1,8'h66,1'b0,11'h000,1'b0,13'h0000,13'h0066,5'h10,8'd8},  // R8 low wins
        '{1'b0,5'h00,1'b0,1'b0,8'h00,1'b0,11'h000,1'b0,13'h0000,13'h0066,5'h10,8'd10}, // R10
        '{1'b1,5'h1F,1'b0,1'b0,8'h00,1'b0,11'h000,1'b0,13'h0000,13'h0066,5'h1F,8'd5},  // R5 readback
        '{1'b0,5'h00,1'b0,1'b0,8'h00,1'b1,11'h000,1'b0,13'h0000,13'h0800,5'h1F,8'd4}   // R4 page 1
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        step_i = 0; lowwr_i = 0; jmp_i = 0; rst_ld_i = 0; hi_wr_i = 0;
        lowwr_data_i = '0; jmp_imm_i = '0; rst_addr_i = '0; hi_wr_data_i = '0;
    endtask

    task automatic check_outputs(input string tag, input logic [12:0] epc, input logic [4:0] ehi);
        chk({tag, " fetch"}, 32'(fetch_addr_o), 32'(epc));
        chk({tag, " hi R5/R9"}, 32'(hi_rd_o), 32'(ehi));
        chk("R11 low byte", 32'(low_rd_o), 32'(epc[7:0]));
        chk("R7 push", 32'(push_addr_o), 32'(13'(epc + 13'd1)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired, all requirements unfinished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        repeat (3) @(negedge clk);
        check_outputs("R1 reset", 13'h0000, 5'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            hi_wr_i = VEC[i].hw; hi_wr_data_i = VEC[i].hd;
            step_i = VEC[i].st; lowwr_i = VEC[i].lw; lowwr_data_i = VEC[i].ld;
            jmp_i = VEC[i].jp; jmp_imm_i = VEC[i].im;
            rst_ld_i = VEC[i].rl; rst_addr_i = VEC[i].ra;
            @(negedge clk);
            check_outputs($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].epc, VEC[i].ehi);
        end
        idle_inputs();

        // R1: asynchronous reset in mid-run clears both registers
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        check_outputs("R1 async reset", 13'h0000, 5'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: computed table jump past a 256-word boundary wraps in block
        hi_wr_i = 1; hi_wr_data_i = 5'h02;
        @(negedge clk);
        hi_wr_i = 0; lowwr_i = 1; lowwr_data_i = 8'hF0;
        @(negedge clk);
        check_outputs("R3 table base", 13'h02F0, 5'h02);
        lowwr_data_i = 8'(8'hF0 + 8'h20);
        @(negedge clk);
        check_outputs("R3 table wrap", 13'h0210, 5'h02);
        idle_inputs();

        // R6: restore ignores latch and keeps it
        rst_ld_i = 1; rst_addr_i = 13'h1555;
        @(negedge clk);
        check_outputs("R6 restore", 13'h1555, 5'h02);
        idle_inputs();
        @(negedge clk);
        check_outputs("R10 idle", 13'h1555, 5'h02);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule